// File: doc/BRIEF.md
# Program Counter with Branch Control

This block holds the instruction address of a single-cycle processor and chooses, on every clock, where the next instruction comes from. There are three choices. The counter can step to the following word. It can add a signed displacement carried in the instruction word, when a condition on the source register holds. It can load an absolute target taken from the register read bus.

The instruction decoder drives the load enable, the jump/branch select and the condition select. The datapath supplies the two status bits of source register A and the bus A value. The current address goes straight to instruction memory.

The displacement arrives as two 3-bit instruction fields. The block joins them and sign-extends the result to the address width. Widths are parameters. A parameter also chooses between a single shared adder and separate increment and target adders.

Top module: `pc_branch_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc_out` to 0 at the next rising edge, whatever the other inputs are.
- R2: With `pc_load` = 0, `pc_out` becomes `pc_out + 1` at each edge, and 0xFFFF steps to 0x0000. `jump_sel`, `cond_neg_sel`, the status bits, the offset fields and `bus_a` have no effect.
- R3: With `pc_load` = 1 and `jump_sel` = 1, `pc_out` is loaded with `bus_a`, whatever the status bits and offset fields are.
- R4: With `pc_load` = 1, `jump_sel` = 0 and `cond_neg_sel` = 1, the branch is taken exactly when `src_neg` = 1. `src_zero` is ignored.
- R5: With `pc_load` = 1, `jump_sel` = 0 and `cond_neg_sel` = 0, the branch is taken exactly when `src_zero` = 1. `src_neg` is ignored.
- R6: A taken branch sets `pc_out` to `pc_out + sext({ofs_hi, ofs_lo})`. Here `ofs_hi` holds bits 5:3 of the 6-bit two's-complement offset and `ofs_lo` holds bits 2:0. Bit 5 is copied into every upper bit. For example, 45 with offset 110100 gives 33.
- R7: A branch whose condition is false sets `pc_out` to `pc_out + 1`.
- R8: Branch addition wraps modulo 2^16. For example, 0x0002 with offset -4 gives 0xFFFE, and 0xFFFE with offset +5 gives 0x0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_load | input | 1 | 0: step by one; 1: jump or branch |
| jump_sel | input | 1 | With pc_load: 1 selects jump, 0 selects branch |
| cond_neg_sel | input | 1 | Branch condition: 1 tests src_neg, 0 tests src_zero |
| src_neg | input | 1 | Source register A is negative |
| src_zero | input | 1 | Source register A is zero |
| ofs_hi | input | 3 | Upper offset field, offset bits 5:3 |
| ofs_lo | input | 3 | Lower offset field, offset bits 2:0 |
| bus_a | input | 16 | Absolute jump target |
| pc_out | output | 16 | Current instruction address |

## Verification
The bench targets these errors:
- Swapping the two offset fields moves a +24 displacement to +3, so positive and negative offsets built from each field alone would land at the wrong address.
- Zero-extending instead of sign-extending turns 45 - 12 into 45 + 52.
- Testing the wrong status bit for a condition makes a branch fire when only the other flag is set, so each condition is driven with the other flag held at the opposite value.
- Wrap-around is checked at both ends of the address space, for both increment and offset addition.
- Reset is applied with a jump pending, so that a reset of lower priority than the jump would be seen.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

   typedef enum logic [1:0] {
      NXT_INC    = 2'd0,
      NXT_BRANCH = 2'd1,
      NXT_JUMP   = 2'd2
   } next_sel_e;

endpackage

// File: rtl/pcb_offset_ext.sv
module pcb_offset_ext #(
   parameter int ADDR_W = 16,
   parameter int FLD_W  = 3
) (
   input  logic [FLD_W-1:0]  fld_hi,
   input  logic [FLD_W-1:0]  fld_lo,
   output logic [ADDR_W-1:0] ofs_ext
);
   localparam int OFS_W = 2 * FLD_W;
   localparam int PAD_W = ADDR_W - OFS_W;

   if (FLD_W < 1) begin : g_bad_fld
      $error("pcb_offset_ext: FLD_W must be at least 1");
   end

   if (PAD_W > 0) begin : g_extend
      assign ofs_ext = {{PAD_W{fld_hi[FLD_W-1]}}, fld_hi, fld_lo};
   end else if (PAD_W == 0) begin : g_exact
      assign ofs_ext = {fld_hi, fld_lo};
   end else begin : g_too_wide
      $error("pcb_offset_ext: offset wider than address");
      assign ofs_ext = '0;
   end
endmodule

// File: rtl/pcb_branch_ctl.sv
module pcb_branch_ctl
   import pcb_pkg::*;
(
   input  logic      pc_load,
   input  logic      jump_sel,
   input  logic      cond_neg_sel,
   input  logic      src_neg,
   input  logic      src_zero,
   output next_sel_e sel
);
   logic cond_hit;

   assign cond_hit = cond_neg_sel ? src_neg : src_zero;

   always_comb begin
      if (!pc_load)      sel = NXT_INC;
      else if (jump_sel) sel = NXT_JUMP;
      else if (cond_hit) sel = NXT_BRANCH;
      else               sel = NXT_INC;
   end
endmodule

// File: rtl/pcb_next_addr.sv
module pcb_next_addr
   import pcb_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit SHARED_ADDER = 1'b0
) (
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [ADDR_W-1:0] ofs_ext,
   input  logic [ADDR_W-1:0] jump_addr,
   input  next_sel_e         sel,
   output logic [ADDR_W-1:0] pc_d
);
   if (ADDR_W < 2) begin : g_bad_w
      $error("pcb_next_addr: ADDR_W must be at least 2");
   end

   if (SHARED_ADDER) begin : g_shared
      logic [ADDR_W-1:0] addend;
      logic [ADDR_W-1:0] sum;
      assign addend = (sel == NXT_BRANCH) ? ofs_ext : ADDR_W'(1);
      assign sum    = pc_q + addend;
      assign pc_d   = (sel == NXT_JUMP) ? jump_addr : sum;
   end else begin : g_dual
      logic [ADDR_W-1:0] inc_addr;
      logic [ADDR_W-1:0] tgt_addr;
      assign inc_addr = pc_q + ADDR_W'(1);
      assign tgt_addr = pc_q + ofs_ext;
      always_comb begin
         case (sel)
            NXT_BRANCH: pc_d = tgt_addr;
            NXT_JUMP:   pc_d = jump_addr;
            default:    pc_d = inc_addr;
         endcase
      end
   end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
   import pcb_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int FLD_W        = 3,
   parameter bit SHARED_ADDER = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pc_load,
   input  logic              jump_sel,
   input  logic              cond_neg_sel,
   input  logic              src_neg,
   input  logic              src_zero,
   input  logic [FLD_W-1:0]  ofs_hi,
   input  logic [FLD_W-1:0]  ofs_lo,
   input  logic [ADDR_W-1:0] bus_a,
   output logic [ADDR_W-1:0] pc_out
);
   localparam int OFS_W = 2 * FLD_W;

   if (OFS_W > ADDR_W) begin : g_bad_cfg
      $error("pc_branch_unit: offset wider than address");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;
   logic [ADDR_W-1:0] ofs_ext;
   next_sel_e         sel;

   pcb_offset_ext #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_ext (
      .fld_hi  (ofs_hi),
      .fld_lo  (ofs_lo),
      .ofs_ext (ofs_ext)
   );

   pcb_branch_ctl u_ctl (
      .pc_load      (pc_load),
      .jump_sel     (jump_sel),
      .cond_neg_sel (cond_neg_sel),
      .src_neg      (src_neg),
      .src_zero     (src_zero),
      .sel          (sel)
   );

   pcb_next_addr #(.ADDR_W(ADDR_W), .SHARED_ADDER(SHARED_ADDER)) u_nxt (
      .pc_q      (pc_q),
      .ofs_ext   (ofs_ext),
      .jump_addr (bus_a),
      .sel       (sel),
      .pc_d      (pc_d)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_d;
   end

   assign pc_out = pc_q;

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_out == '0)); // R1

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(pc_load)) |->
         (pc_out == ADDR_W'($past(pc_out) + ADDR_W'(1)))); // R2

   AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pc_load && jump_sel)) |->
         (pc_out == $past(bus_a))); // R3

   AST_TAKEN_ADD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pc_load && !jump_sel &&
         (cond_neg_sel ? src_neg : src_zero))) |->
         (pc_out == ADDR_W'($past(pc_out) +
            {{(ADDR_W-OFS_W){$past(ofs_hi[FLD_W-1])}}, $past(ofs_hi), $past(ofs_lo)}))); // R6

   AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(pc_load && !jump_sel &&
         !(cond_neg_sel ? src_neg : src_zero))) |->
         (pc_out == ADDR_W'($past(pc_out) + ADDR_W'(1)))); // R7
endmodule

// File: tb/pc_branch_unit_tb_top.sv
module pc_branch_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pc_load = 1'b0;
   logic        jump_sel = 1'b0;
   logic        cond_neg_sel = 1'b0;
   logic        src_neg = 1'b0;
   logic        src_zero = 1'b0;
   logic [2:0]  ofs_hi = 3'd0;
   logic [2:0]  ofs_lo = 3'd0;
   logic [15:0] bus_a = 16'd0;
   logic [15:0] pc_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pc_branch_unit dut_i (
      .clk(clk), .rst(rst), .pc_load(pc_load), .jump_sel(jump_sel),
      .cond_neg_sel(cond_neg_sel), .src_neg(src_neg), .src_zero(src_zero),
      .ofs_hi(ofs_hi), .ofs_lo(ofs_lo), .bus_a(bus_a), .pc_out(pc_out)
   );

   task automatic step(input logic pl, input logic jb, input logic bc,
                       input logic n, input logic z,
                       input logic [2:0] hi, input logic [2:0] lo,
                       input logic [15:0] a);
      pc_load = pl; jump_sel = jb; cond_neg_sel = bc;
      src_neg = n; src_zero = z; ofs_hi = hi; ofs_lo = lo; bus_a = a;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [15:0] exp);
      n_chk++;
      if (pc_out !== exp) begin
         n_err++;
         $display("FAIL %s pc_out=%h expected=%h", req, pc_out, exp);
      end
   endtask

   task automatic jump_to(input logic [15:0] a);
      step(1, 1, 0, 0, 0, 3'd0, 3'd0, a);
      check("R3", a);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      step(1, 1, 0, 0, 0, 3'd0, 3'd0, 16'h1234);
      check("R1", 16'h0000);
      step(0, 0, 0, 0, 0, 3'd0, 3'd0, 16'h0000);
      check("R1", 16'h0000);
      rst = 1'b0;
   endtask

   task automatic t_increment;
      step(0, 1, 1, 1, 1, 3'b111, 3'b111, 16'hBEEF);
      check("R2", 16'h0001);
      step(0, 0, 1, 1, 0, 3'b010, 3'b001, 16'h0000);
      check("R2", 16'h0002);
      step(0, 0, 0, 0, 1, 3'b100, 3'b000, 16'h7777);
      check("R2", 16'h0003);
      jump_to(16'hFFFF);
      step(0, 0, 0, 0, 0, 3'd0, 3'd0, 16'h0000);
      check("R2 wrap", 16'h0000);
   endtask

   task automatic t_jump;
      step(1, 1, 1, 1, 1, 3'b101, 3'b010, 16'hA5C3);
      check("R3", 16'hA5C3);
      step(1, 1, 0, 1, 1, 3'b111, 3'b111, 16'h0000);
      check("R3", 16'h0000);
   endtask

   task automatic t_branch_neg;
      jump_to(16'd100);
      step(1, 0, 1, 1, 0, 3'b000, 3'b011, 16'hFFFF);
      check("R4 taken", 16'd103);
      step(1, 0, 1, 0, 1, 3'b000, 3'b011, 16'hFFFF);
      check("R4 zero ignored / R7", 16'd104);
   endtask

   task automatic t_branch_zero;
      step(1, 0, 0, 0, 1, 3'b001, 3'b000, 16'hFFFF);
      check("R5 taken", 16'd112);
      step(1, 0, 0, 1, 0, 3'b001, 3'b000, 16'hFFFF);
      check("R5 neg ignored / R7", 16'd113);
   endtask

   task automatic t_offset;
      jump_to(16'd45);
      step(1, 0, 0, 0, 1, 3'b110, 3'b100, 16'h0000);
      check("R6 -12", 16'd33);
      step(1, 0, 0, 0, 1, 3'b011, 3'b111, 16'h0000);
      check("R6 +31", 16'd64);
      step(1, 0, 1, 1, 0, 3'b100, 3'b000, 16'h0000);
      check("R6 -32", 16'd32);
      step(1, 0, 1, 1, 0, 3'b000, 3'b111, 16'h0000);
      check("R6 lo only", 16'd39);
   endtask

   task automatic t_wrap;
      jump_to(16'h0002);
      step(1, 0, 0, 0, 1, 3'b111, 3'b100, 16'h0000);
      check("R8 down", 16'hFFFE);
      step(1, 0, 1, 1, 0, 3'b000, 3'b101, 16'h0000);
      check("R8 up", 16'h0003);
   endtask

   initial begin
      #1;
      t_reset();
      t_increment();
      t_jump();
      t_branch_neg();
      t_branch_zero();
      t_offset();
      t_wrap();
      t_reset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog run=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule